// File: doc/BRIEF.md
# AXI Critical Read Ordering Gate

This block sits between a read request source and the read-address (AR) channel of an AXI master port. It passes ordinary reads straight through. It holds back reads it classifies as critical until earlier AXI traffic has drained. A read is critical when it targets Device or Strongly-ordered memory, or when it is an exclusive load to shareable memory.

Two counters track traffic on the port. One counts reads whose last data beat has not yet returned. The other counts stores whose write response has not yet arrived. Two configuration bits are captured on a load strobe. One makes critical reads wait for outstanding reads to reach zero. The other makes them wait for outstanding stores to reach zero. Setting both bits makes a critical read wait for both counts.

The gate can only delay a request; it never withdraws one. Once a critical read appears on AR, it stays there until the slave accepts it. The request source must keep `req_valid` and its attributes steady until `req_ready` is high.

Top module: `axi_crit_read_gate`

## Requirements
- R1: A read is critical when `req_mem` is 1 (Device) or 2 (Strongly-ordered), or when both `req_excl` and `req_shared` are high. `req_mem` values 0 and 3 are normal memory. An exclusive read with `req_shared` low, to normal memory, is not critical.
- R2: A non-critical read drives `m_arvalid` equal to `req_valid` in the same cycle, whatever the configuration and counter values.
- R3: With the read-wait bit set, `m_arvalid` stays low for a critical read while any read is outstanding. The read count rises on each AR handshake. It falls only on an R handshake with `m_rlast` high, so beats without `m_rlast` leave it unchanged.
- R4: With the store-wait bit set, `m_arvalid` stays low for a critical read while any store is outstanding. A store is outstanding from its AW handshake until its B handshake. A B beat with `m_bready` low does not complete it. With only this bit set, outstanding reads do not delay the read.
- R5: With both wait bits clear, a critical read is presented in the same cycle as `req_valid`, even with reads and stores outstanding.
- R6: Once `m_arvalid` has been high without `m_arready`, it stays high until the handshake. This holds even if a counter becomes non-zero in the meantime.
- R7: After reset both counters are zero and both wait bits are clear, so a critical read is presented at once.
- R8: The wait bits change only in a cycle with `cfg_load` high. With both bits set, a critical read waits until both counts are zero; clearing only the store count does not release it.
- R9: `req_ready` is high exactly when `m_arvalid` and `m_arready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures the two wait bits |
| cfg_rur_in | input | 1 | Wait for outstanding reads before a critical read |
| cfg_ruw_in | input | 1 | Wait for outstanding stores before a critical read |
| req_valid | input | 1 | A read request is pending |
| req_mem | input | 2 | Memory type: 0 normal, 1 Device, 2 Strongly-ordered, 3 normal |
| req_excl | input | 1 | Request is an exclusive load |
| req_shared | input | 1 | Request targets shareable memory |
| req_ready | output | 1 | Request accepted on AR this cycle |
| m_arvalid | output | 1 | AR valid toward the interconnect |
| m_arready | input | 1 | AR ready from the interconnect |
| m_rvalid | input | 1 | R channel valid |
| m_rready | input | 1 | R channel ready |
| m_rlast | input | 1 | Last beat of a read burst |
| m_awvalid | input | 1 | AW channel valid |
| m_awready | input | 1 | AW channel ready |
| m_bvalid | input | 1 | B channel valid |
| m_bready | input | 1 | B channel ready |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- Read beats without RLAST. A design that counted every R beat would release a critical read after the first beat of a burst.
- A B beat that is not accepted. A design that counted it would release a critical read before the store has completed.
- An exclusive read to non-shareable memory, and a bare exclusive flag. A design with a wrong classification would stall these reads or let a critical one slip through.
- A store handshake in the same cycle that a critical read is first offered. A design without the hold state would drop AR valid and break channel stability.
- Changes to the configuration inputs without the load strobe. A design that ignored the strobe would change its behaviour.
- Both wait bits set, with only one counter drained. A design that combined the two conditions wrongly would release the read too early.

// File: rtl/axi_crit_read_gate.sv
module axi_crit_read_gate #(
  parameter int OUTST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic               cfg_rur_in,
  input  logic               cfg_ruw_in,
  input  logic               req_valid,
  input  logic [1:0]         req_mem,
  input  logic               req_excl,
  input  logic               req_shared,
  output logic               req_ready,
  output logic               m_arvalid,
  input  logic               m_arready,
  input  logic               m_rvalid,
  input  logic               m_rready,
  input  logic               m_rlast,
  input  logic               m_awvalid,
  input  logic               m_awready,
  input  logic               m_bvalid,
  input  logic               m_bready
);
  localparam logic [OUTST_W-1:0] CNT_MAX = {OUTST_W{1'b1}};
  localparam logic [1:0] MEM_DEV = 2'd1;
  localparam logic [1:0] MEM_SO  = 2'd2;

  logic               cfg_rur, cfg_ruw, held;
  logic [OUTST_W-1:0] rd_cnt, wr_cnt;
  logic               is_crit, stall, ar_hs, rd_done, aw_hs, b_hs;

  assign is_crit = (req_mem == MEM_DEV) || (req_mem == MEM_SO) || (req_excl && req_shared);
  assign stall   = is_crit && !held &&
                   ((cfg_rur && rd_cnt != '0) || (cfg_ruw && wr_cnt != '0));

  assign m_arvalid = req_valid && !stall;
  assign req_ready = m_arvalid && m_arready;

  assign ar_hs   = m_arvalid && m_arready;
  assign rd_done = m_rvalid && m_rready && m_rlast;
  assign aw_hs   = m_awvalid && m_awready;
  assign b_hs    = m_bvalid && m_bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rur <= 1'b0;
      cfg_ruw <= 1'b0;
    end else if (cfg_load) begin
      cfg_rur <= cfg_rur_in;
      cfg_ruw <= cfg_ruw_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    held <= 1'b0;
    else if (ar_hs)                held <= 1'b0;
    else if (m_arvalid)            held <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_cnt <= '0;
    else case ({ar_hs, rd_done})
      2'b10:   rd_cnt <= rd_cnt + 1'b1;
      2'b01:   rd_cnt <= rd_cnt - 1'b1;
      default: rd_cnt <= rd_cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_cnt <= '0;
    else case ({aw_hs, b_hs})
      2'b10:   wr_cnt <= wr_cnt + 1'b1;
      2'b01:   wr_cnt <= wr_cnt - 1'b1;
      default: wr_cnt <= wr_cnt;
    endcase
  end

  // R2
  p_noncrit_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_crit) |-> m_arvalid);
  // R3
  p_rur_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && is_crit && cfg_rur && !held) |-> (rd_cnt == '0));
  // R4
  p_ruw_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && is_crit && cfg_ruw && !held) |-> (wr_cnt == '0));
  // R6
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> m_arvalid);
  // R3
  p_rd_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == CNT_MAX) |-> !(ar_hs && !rd_done));
  // R4
  p_wr_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt == CNT_MAX) |-> !(aw_hs && !b_hs));
  // R3
  p_rd_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == '0) |-> !(rd_done && !ar_hs));
  // R9
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (m_arvalid && m_arready));
endmodule

// File: tb/sim_axi_crit_read_gate.sv
`timescale 1ns/1ps
module sim_axi_crit_read_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 0, cfg_rur_in = 0, cfg_ruw_in = 0;
  logic req_valid = 0, req_excl = 0, req_shared = 0;
  logic [1:0] req_mem = 2'd0;
  logic req_ready, m_arvalid;
  logic m_arready = 0, m_rvalid = 0, m_rready = 0, m_rlast = 0;
  logic m_awvalid = 0, m_awready = 0, m_bvalid = 0, m_bready = 0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  axi_crit_read_gate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_rur_in(cfg_rur_in),
    .cfg_ruw_in(cfg_ruw_in), .req_valid(req_valid), .req_mem(req_mem),
    .req_excl(req_excl), .req_shared(req_shared), .req_ready(req_ready),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_rvalid(m_rvalid),
    .m_rready(m_rready), .m_rlast(m_rlast), .m_awvalid(m_awvalid),
    .m_awready(m_awready), .m_bvalid(m_bvalid), .m_bready(m_bready));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic rur, input logic ruw);
    @(negedge clk); cfg_load = 1; cfg_rur_in = rur; cfg_ruw_in = ruw;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic r_beat(input logic last);
    @(negedge clk); m_rvalid = 1; m_rready = 1; m_rlast = last;
    @(negedge clk); m_rvalid = 0; m_rready = 0; m_rlast = 0;
  endtask

  task automatic aw_hs();
    @(negedge clk); m_awvalid = 1; m_awready = 1;
    @(negedge clk); m_awvalid = 0; m_awready = 0;
  endtask

  task automatic b_beat(input logic rdy);
    @(negedge clk); m_bvalid = 1; m_bready = rdy;
    @(negedge clk); m_bvalid = 0; m_bready = 0;
  endtask

  task automatic hold_req(input logic [1:0] mem, input logic ex, input logic sh);
    @(negedge clk); req_valid = 1; req_mem = mem; req_excl = ex; req_shared = sh; m_arready = 0;
  endtask

  task automatic accept();
    m_arready = 1;
    @(negedge clk); req_valid = 0; m_arready = 0; req_excl = 0; req_shared = 0; req_mem = 0;
  endtask

  task automatic drop();
    @(negedge clk); req_valid = 0; req_excl = 0; req_shared = 0; req_mem = 0;
  endtask

  task automatic t_reset();
    hold_req(2'd2, 0, 0); #1;
    chk(m_arvalid, 1, "R7 SO read presented after reset");
    chk(req_ready, 0, "R9 no ready without arready");
    m_arready = 1; #1;
    chk(req_ready, 1, "R9 ready on handshake");
    accept();
  endtask

  task automatic t_noncrit();
    set_cfg(1, 1);
    aw_hs();
    hold_req(2'd0, 0, 0); #1; chk(m_arvalid, 1, "R2 normal read passes");
    accept();
    hold_req(2'd3, 1, 0); #1; chk(m_arvalid, 1, "R1 exclusive non-shared is normal");
    accept();
    hold_req(2'd0, 0, 1); #1; chk(m_arvalid, 1, "R1 shared non-exclusive is normal");
    accept();
    hold_req(2'd0, 1, 1); #1; chk(m_arvalid, 0, "R1 exclusive shared is critical");
    drop();
  endtask

  task automatic t_rur();
    set_cfg(1, 0);
    hold_req(2'd1, 0, 0); #1; chk(m_arvalid, 0, "R3 device read waits on reads");
    r_beat(0); #1; chk(m_arvalid, 0, "R3 beat without last keeps count");
    r_beat(1); r_beat(1); r_beat(1); #1; chk(m_arvalid, 0, "R3 one read still outstanding");
    r_beat(1); #1; chk(m_arvalid, 1, "R3 released at zero reads");
    accept();
  endtask

  task automatic t_ruw();
    set_cfg(0, 1);
    hold_req(2'd0, 1, 1); #1; chk(m_arvalid, 0, "R4 exclusive shared waits on store");
    b_beat(0); #1; chk(m_arvalid, 0, "R4 unaccepted B does not complete store");
    b_beat(1); #1; chk(m_arvalid, 1, "R4 released with a read outstanding");
    accept();
  endtask

  task automatic t_none();
    set_cfg(0, 0);
    aw_hs();
    hold_req(2'd2, 0, 0); #1; chk(m_arvalid, 1, "R5 no wait with bits clear");
    accept();
  endtask

  task automatic t_both();
    set_cfg(1, 1);
    hold_req(2'd1, 0, 0); #1; chk(m_arvalid, 0, "R8 both bits blocks");
    b_beat(1); #1; chk(m_arvalid, 0, "R8 stores drained, reads remain");
    r_beat(1); r_beat(1); r_beat(1); #1; chk(m_arvalid, 1, "R8 released when both zero");
    accept();
    r_beat(1);
  endtask

  task automatic t_stable();
    set_cfg(0, 1);
    @(negedge clk); req_valid = 1; req_mem = 2'd2; m_arready = 0; m_awvalid = 1; m_awready = 1;
    #1; chk(m_arvalid, 1, "R6 offered with no stores");
    @(negedge clk); m_awvalid = 0; m_awready = 0;
    #1; chk(m_arvalid, 1, "R6 valid kept after store started");
    chk(req_ready, 0, "R9 still not accepted");
    accept();
    @(negedge clk); cfg_rur_in = 0; cfg_ruw_in = 0;
    hold_req(2'd1, 0, 0); #1; chk(m_arvalid, 0, "R8 config ignored without load");
    drop();
    b_beat(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_noncrit();
    t_rur();
    t_ruw();
    t_none();
    t_both();
    t_stable();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule